// File: doc/BRIEF.md
# Link Receiver Lock Sequencer

This block is the timing-and-control sequencer of a serial link receiver. After power is applied it waits for the local PLL to lock to the reference clock. It then searches the incoming serial stream for a transition word and declares lock when one arrives. Lock is shown on an active-low indicator. The parallel data outputs and the output clock follow a fixed rule per state: high impedance, forced low, or valid. The output clock source is either the reference clock or the recovered clock, and the clock is held high for one extra period at every switch between the two.

Once locked, the sequencer keeps watching for transition words. If none arrives within a programmable window, or if the line stops toggling, it drops lock, forces the data low, returns the output clock to the reference, and searches again. A build option adds a spread-spectrum PLL. That option lengthens the PLL wait and adds a fixed settle delay between finding the word and declaring lock. An output-enable pin tri-states everything except the lock indicator. The PLLs are modelled by counters. Tri-state drivers are represented by drive-enable flags. All pins are plain control and status signals; there is no streaming interface.

Top module: `link_lock_ctrl`

## Requirements
- R1: While reset is asserted, and from one cycle after `pwr_on` is sampled low, `lock_drv`=0, `oclk_drv`=0 and `data_mode`=00 (high impedance).
- R2: One cycle after `pwr_on` is first sampled high, `lock_drv`=1, `lock_n`=1, `data_mode`=01 (forced low), `oclk_drv`=1 and `oclk_rec`=0 (reference clock).
- R3: The PLL wait lasts `LOCK_CYCLES` cycles, and transition words are ignored during it. With a word present on every cycle, `lock_n` is still 1 after `LOCK_CYCLES` edges counted from the edge that first samples `pwr_on` high, and it is 0 after one more edge.
- R4: In search, a cycle in which `xword_hit`=1 and `rx_active`=1 makes `lock_n`=0 and `data_mode`=10 (valid) on the next cycle.
- R5: With `SPREAD`=1, the PLL wait is `SS_LOCK_CYCLES` long, and lock follows the word after a further `SETTLE_CYCLES` cycles. The total is `SS_LOCK_CYCLES`+1+`SETTLE_CYCLES` edges from power-up.
- R6: One cycle after `lock_n` changes, `oclk_rec` takes the new source (1 = recovered clock), and `oclk_hold`=1 for exactly that cycle.
- R7: While locked, `SEARCH_LIMIT` consecutive sampled cycles without a word drop lock: `lock_n`=1 and `data_mode`=01. A word on the last of those cycles keeps lock.
- R8: `rx_active`=0 while locked drops lock on the next cycle (`lock_n`=1, `data_mode`=01, clock back to the reference).
- R9: In search, `xword_hit` is ignored while `rx_active`=0.
- R10: `out_en`=0 forces, in the same cycle, `data_mode`=00 and `oclk_drv`=0. It leaves `lock_n` and `lock_drv` unchanged.
- R11: After a timeout the search continues, and a later word restores lock.
- R12: Dropping `pwr_on` while locked powers the block off on the next cycle. Raising it again restarts the full PLL wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Run enable; low powers the receiver down |
| rx_active | input | 1 | Serial line is toggling |
| xword_hit | input | 1 | Transition word seen in this cycle |
| out_en | input | 1 | Output enable for data and output clock |
| lock_n | output | 1 | Active-low lock indicator value |
| lock_drv | output | 1 | Lock indicator is driven (0 = high impedance) |
| data_mode | output | 2 | 00 high impedance, 01 forced low, 10 valid |
| oclk_drv | output | 1 | Output clock is driven |
| oclk_rec | output | 1 | Output clock source: 0 reference, 1 recovered |
| oclk_hold | output | 1 | Output clock held high this cycle (switch stretch) |

## Verification
The bench measures the exact power-up-to-lock latency of both variants. A design with an off-by-one in the PLL or settle counter, or one that accepts words during the PLL wait, locks one or more cycles early or late. The watchdog boundary is probed with a word on the last allowed cycle and then with no word at all. A counter that is one short drops lock too soon, and one that is one long never drops lock at the expected edge. Randomized output-enable and word gaps check that disabling the outputs never disturbs the lock indicator, and that activity loss and words arriving without line activity are handled as required.

// File: rtl/lock_ctrl_pkg.sv
package lock_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_PLL    = 3'd1,
    ST_SEARCH = 3'd2,
    ST_SETTLE = 3'd3,
    ST_LOCKED = 3'd4
  } lk_state_t;

  typedef enum logic [1:0] {
    DM_HIZ   = 2'b00,
    DM_LOW   = 2'b01,
    DM_VALID = 2'b10
  } dmode_t;
endpackage

// File: rtl/lk_down_timer.sv
module lk_down_timer #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             dec,
  output logic             done
);
  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R3
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/lk_seq_fsm.sv
module lk_seq_fsm
  import lock_ctrl_pkg::*;
#(
  parameter bit SPREAD = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_on,
  input  logic      rx_active,
  input  logic      xword_hit,
  input  logic      phase_done,
  input  logic      wd_done,
  output lk_state_t state,
  output logic      phase_load,
  output logic      phase_pll_sel,
  output logic      phase_dec,
  output logic      wd_load,
  output logic      wd_dec
);
  lk_state_t nxt;
  lk_state_t found_st;

  generate
    if (SPREAD) begin : g_settle
      assign found_st = ST_SETTLE;
    end else begin : g_direct
      assign found_st = ST_LOCKED;
    end
  endgenerate

  always_comb begin
    nxt = state;
    if (!pwr_on) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:    nxt = ST_PLL;
        ST_PLL:    if (phase_done) nxt = ST_SEARCH;
        ST_SEARCH: if (rx_active && xword_hit) nxt = found_st;
        ST_SETTLE: begin
          if (!rx_active)      nxt = ST_SEARCH;
          else if (phase_done) nxt = ST_LOCKED;
        end
        ST_LOCKED: begin
          if (!rx_active)                nxt = ST_SEARCH;
          else if (wd_done && !xword_hit) nxt = ST_SEARCH;
        end
        default:   nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

  assign phase_load    = (state == ST_OFF) || (state == ST_SEARCH);
  assign phase_pll_sel = (state == ST_OFF);
  assign phase_dec     = (state == ST_PLL) || (state == ST_SETTLE);
  assign wd_load       = (state != ST_LOCKED) || xword_hit;
  assign wd_dec        = (state == ST_LOCKED);

  // R1
  off_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (state == ST_OFF));
  // R9
  word_needs_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEARCH && pwr_on && !rx_active) |=> (state == ST_SEARCH));
  // R8
  activity_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCKED && !rx_active) |=> (state != ST_LOCKED));
endmodule

// File: rtl/lk_clk_switch.sv
module lk_clk_switch (
  input  logic clk,
  input  logic rst_n,
  input  logic want_rec,
  output logic rec_q,
  output logic stretch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q     <= 1'b0;
      stretch_q <= 1'b0;
    end else begin
      rec_q     <= want_rec;
      stretch_q <= (want_rec != rec_q);
    end
  end

  // R6
  stretch_follows_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (want_rec != rec_q) |=> stretch_q);
endmodule

// File: rtl/lk_out_stage.sv
module lk_out_stage
  import lock_ctrl_pkg::*;
(
  input  lk_state_t   state,
  input  logic        out_en,
  input  logic        rec_q,
  input  logic        stretch_q,
  output logic        lock_n,
  output logic        lock_drv,
  output logic [1:0]  data_mode,
  output logic        oclk_drv,
  output logic        oclk_rec,
  output logic        oclk_hold
);
  logic powered;
  logic locked;

  assign powered  = (state != ST_OFF);
  assign locked   = (state == ST_LOCKED);
  assign lock_drv = powered;
  assign lock_n   = !locked;
  assign oclk_drv = powered && out_en;
  assign oclk_rec = rec_q;
  assign oclk_hold = stretch_q && oclk_drv;

  always_comb begin
    if (!powered || !out_en) data_mode = DM_HIZ;
    else if (locked)         data_mode = DM_VALID;
    else                     data_mode = DM_LOW;
  end
endmodule

// File: rtl/link_lock_ctrl.sv
module link_lock_ctrl
  import lock_ctrl_pkg::*;
#(
  parameter bit SPREAD         = 1'b0,
  parameter int LOCK_CYCLES    = 16928,
  parameter int SS_LOCK_CYCLES = 33600,
  parameter int SETTLE_CYCLES  = 288,
  parameter int SEARCH_LIMIT   = 4194304
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on,
  input  logic       rx_active,
  input  logic       xword_hit,
  input  logic       out_en,
  output logic       lock_n,
  output logic       lock_drv,
  output logic [1:0] data_mode,
  output logic       oclk_drv,
  output logic       oclk_rec,
  output logic       oclk_hold
);
  localparam int LOCK_N  = SPREAD ? SS_LOCK_CYCLES : LOCK_CYCLES;
  localparam int PH_MAX  = (LOCK_N > SETTLE_CYCLES) ? LOCK_N : SETTLE_CYCLES;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int WD_W    = $clog2(SEARCH_LIMIT + 1);
  localparam logic [PH_W-1:0] PH_PLL_VAL    = PH_W'(LOCK_N - 1);
  localparam logic [PH_W-1:0] PH_SETTLE_VAL = PH_W'(SETTLE_CYCLES - 1);
  localparam logic [WD_W-1:0] WD_VAL        = WD_W'(SEARCH_LIMIT - 1);

  lk_state_t        state;
  logic             phase_load, phase_pll_sel, phase_dec, phase_done;
  logic             wd_load, wd_dec, wd_done;
  logic [PH_W-1:0]  phase_val;
  logic             rec_q, stretch_q;

  assign phase_val = phase_pll_sel ? PH_PLL_VAL : PH_SETTLE_VAL;

  lk_seq_fsm #(.SPREAD(SPREAD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .rx_active(rx_active),
    .xword_hit(xword_hit), .phase_done(phase_done), .wd_done(wd_done),
    .state(state), .phase_load(phase_load), .phase_pll_sel(phase_pll_sel),
    .phase_dec(phase_dec), .wd_load(wd_load), .wd_dec(wd_dec)
  );

  lk_down_timer #(.WIDTH(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(phase_load), .load_val(phase_val),
    .dec(phase_dec), .done(phase_done)
  );

  lk_down_timer #(.WIDTH(WD_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .load(wd_load), .load_val(WD_VAL),
    .dec(wd_dec), .done(wd_done)
  );

  lk_clk_switch u_clk (
    .clk(clk), .rst_n(rst_n), .want_rec(state == ST_LOCKED),
    .rec_q(rec_q), .stretch_q(stretch_q)
  );

  lk_out_stage u_out (
    .state(state), .out_en(out_en), .rec_q(rec_q), .stretch_q(stretch_q),
    .lock_n(lock_n), .lock_drv(lock_drv), .data_mode(data_mode),
    .oclk_drv(oclk_drv), .oclk_rec(oclk_rec), .oclk_hold(oclk_hold)
  );

  // R6
  lock_moves_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_drv && $fell(lock_n)) |=> (oclk_rec && (oclk_hold || !oclk_drv)));
  // R2
  powerup_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_drv) |-> (lock_n && !oclk_rec));
  // R4
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mode == DM_VALID) |-> (!lock_n && oclk_drv));
endmodule

// File: tb/link_lock_ctrl_test.sv
`timescale 1ns/1ps
module link_lock_ctrl_test;
  localparam int N  = 20;
  localparam int SS = 30;
  localparam int W  = 6;
  localparam int LIM = 50;

  logic clk = 1'b0;
  logic rst_n, pwr_on, rx_active, xword_hit, out_en;
  logic lock_n, lock_drv, oclk_drv, oclk_rec, oclk_hold;
  logic [1:0] data_mode;
  logic s_lock_n, s_lock_drv, s_oclk_drv, s_oclk_rec, s_oclk_hold;
  logic [1:0] s_data_mode;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  link_lock_ctrl #(.SPREAD(1'b0), .LOCK_CYCLES(N), .SS_LOCK_CYCLES(SS),
    .SETTLE_CYCLES(W), .SEARCH_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .rx_active(rx_active),
    .xword_hit(xword_hit), .out_en(out_en), .lock_n(lock_n),
    .lock_drv(lock_drv), .data_mode(data_mode), .oclk_drv(oclk_drv),
    .oclk_rec(oclk_rec), .oclk_hold(oclk_hold));

  link_lock_ctrl #(.SPREAD(1'b1), .LOCK_CYCLES(N), .SS_LOCK_CYCLES(SS),
    .SETTLE_CYCLES(W), .SEARCH_LIMIT(LIM)) uut_ss (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .rx_active(rx_active),
    .xword_hit(xword_hit), .out_en(out_en), .lock_n(s_lock_n),
    .lock_drv(s_lock_drv), .data_mode(s_data_mode), .oclk_drv(s_oclk_drv),
    .oclk_rec(s_oclk_rec), .oclk_hold(s_oclk_hold));

  function automatic logic [1:0] exp_mode(bit powered, bit locked, bit oe);
    if (!powered || !oe) return 2'b00;
    return locked ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    rst_n = 0; pwr_on = 0; rx_active = 0; xword_hit = 0; out_en = 1;
    step(3);
    // R1 reset state
    chk("R1", lock_drv, 0, "lock_drv in reset");
    chk("R1", data_mode, exp_mode(0, 0, 1), "data_mode in reset");
    chk("R1", oclk_drv, 0, "oclk_drv in reset");
    rst_n = 1;
    step(2);
    chk("R1", {s_lock_drv, s_oclk_drv}, 0, "spread variant off");

    // R2 / R3 power-up, word present every cycle
    rx_active = 1; xword_hit = 1; pwr_on = 1;
    step(1);
    chk("R2", lock_drv, 1, "lock driven");
    chk("R2", lock_n, 1, "lock high");
    chk("R2", data_mode, exp_mode(1, 0, 1), "data forced low");
    chk("R2", {oclk_drv, oclk_rec}, 2'b10, "clock from reference");
    step(N);
    chk("R3", lock_n, 1, "no lock during PLL wait");
    step(1);
    chk("R3", lock_n, 0, "lock right after PLL wait");
    chk("R4", data_mode, exp_mode(1, 1, 1), "data valid on lock");
    chk("R6", {oclk_rec, oclk_hold}, 2'b00, "reference still selected");
    step(1);
    chk("R6", {oclk_rec, oclk_hold}, 2'b11, "switch with stretch");
    step(1);
    chk("R6", {oclk_rec, oclk_hold}, 2'b10, "stretch lasts one cycle");

    // R5 spread variant total latency
    step(SS + W - (N + 3));
    chk("R5", s_lock_n, 1, "spread not yet locked");
    step(1);
    chk("R5", s_lock_n, 0, "spread locked after settle");

    // R7 watchdog boundary
    xword_hit = 0;
    step(LIM - 1);
    chk("R7", lock_n, 0, "lock held before limit");
    xword_hit = 1;
    step(1);
    chk("R7", lock_n, 0, "word on last cycle keeps lock");
    xword_hit = 0;
    step(LIM - 1);
    chk("R7", lock_n, 0, "still locked one short");
    step(1);
    chk("R7", lock_n, 1, "timeout drops lock");
    chk("R7", data_mode, exp_mode(1, 0, 1), "data low after timeout");
    step(1);
    chk("R6", {oclk_rec, oclk_hold}, 2'b01, "back to reference with stretch");
    step(1);
    chk("R6", {oclk_rec, oclk_hold}, 2'b00, "reference stretch done");

    // R11 search continues
    step(10);
    chk("R11", lock_n, 1, "searching");
    xword_hit = 1;
    step(1);
    chk("R11", lock_n, 0, "relock after timeout");
    xword_hit = 0;

    // R8 activity loss
    rx_active = 0;
    step(1);
    chk("R8", lock_n, 1, "lock drop on idle line");
    chk("R8", data_mode, exp_mode(1, 0, 1), "data low on idle line");
    // R9 words ignored without activity
    xword_hit = 1;
    step(3);
    chk("R9", lock_n, 1, "word ignored while idle");
    rx_active = 1;
    step(1);
    chk("R4", lock_n, 0, "word with activity locks");

    // R10 random output enable with word gaps below limit
    begin
      int gap = 0;
      for (int i = 0; i < 300; i++) begin
        @(posedge clk); #1;
        out_en = 1'($urandom % 2);
        xword_hit = (($urandom % 4) == 0) || (gap >= 20);
        gap = xword_hit ? 0 : gap + 1;
        #1;
        chk("R10", {lock_drv, lock_n}, 2'b10, "lock untouched by enable");
        chk("R10", data_mode, exp_mode(1, 1, out_en), "data mode vs enable");
        chk("R10", oclk_drv, out_en, "clock drive vs enable");
      end
    end
    out_en = 1;
    xword_hit = 0;

    // R12 power cycle restarts PLL wait
    step(1);
    pwr_on = 0;
    step(1);
    chk("R12", {lock_drv, oclk_drv}, 2'b00, "off after pwr_on low");
    chk("R1", data_mode, exp_mode(0, 0, 1), "data hiz when off");
    step(2);
    pwr_on = 1; xword_hit = 1;
    step(1);
    chk("R12", lock_n, 1, "restart unlocked");
    step(N);
    chk("R12", lock_n, 1, "full PLL wait again");
    step(1);
    chk("R12", lock_n, 0, "lock after restart");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule